// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for an 8-bit converter that talks over three wires: an active-low chip select, an I/O clock driven by the host, and a single data line driven by the converter. A one-cycle start request makes the controller lower chip select and wait a fixed setup time. It then emits eight I/O clock pulses, each half period lasting a number of system clocks given on a divider input, and shifts in the returned bits, most significant first. After the eighth pulse it raises chip select and presents the byte with a one-cycle valid strobe.

The converter starts a new conversion on the eighth falling clock edge, so the byte returned by an access is the result of the conversion that the previous access started. The controller therefore keeps chip select high for a guard interval long enough for that conversion to finish. It marks the first byte after reset as stale, since no earlier access launched a conversion for it. A start request that arrives while an access or the guard interval is running is remembered and served as soon as the controller is idle again. Several such requests merge into one.

Top module: `sadc_reader`

## Requirements
- R1: During and right after reset, adc_cs_n is 1, adc_sclk is 0 and rd_valid is 0.
- R2: A start seen while idle lowers adc_cs_n from the next cycle. adc_sclk stays 0 for SETUP_CYC cycles before its first rise.
- R3: Each access has exactly 8 high pulses on adc_sclk. Each pulse lasts H cycles and the gaps between pulses last H cycles, where H = max(half_div, 1) sampled in the cycle the access is accepted. Later changes of half_div do not affect a running access.
- R4: adc_sdo is sampled in the cycle adc_sclk rises, so the MSB is taken before the first falling edge. The 8 samples fill rd_data MSB first, and rd_data holds its value until the next strobe.
- R5: adc_cs_n rises in the same cycle as the eighth falling edge of adc_sclk. rd_valid is high for exactly that one cycle, the first cycle with adc_cs_n high.
- R6: Between the end of one access and the start of the next, adc_cs_n stays high for at least G+1 cycles, where G = max(CONV_CYC, CSH_CYC).
- R7: A start that arrives while an access or the guard interval is running is held pending and starts one access after the guard interval. Any number of such starts during one access produce exactly one extra access.
- R8: rd_stale is 1 with the first rd_valid after reset and 0 with every later one.
- R9: adc_sclk is 0 in every cycle in which adc_cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request for a read access |
| half_div | input | DIV_W | I/O clock half period in system clocks (0 treated as 1) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter I/O clock, idles low |
| adc_sdo | input | 1 | Serial data from the converter |
| rd_valid | output | 1 | One-cycle strobe when a new byte is available |
| rd_data | output | DATA_W | Last byte read, MSB received first |
| rd_stale | output | 1 | Set with the strobe when the byte predates any requested conversion |

## Verification
The hardest case to reach from the ports is a start request that lands within a cycle or two of the guard interval ending. In that window the request is either held pending or accepted directly from idle, and a one-cycle slip would change when chip select falls. The stimulus follows a behavioural model of the access timeline. It fires start at each of the last few guard cycles in turn and also during an active frame, while the divider input changes mid-access. Chip select, the I/O clock and the strobe are compared against the model on every cycle.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_SETUP = 3'd1,
        SQ_HIGH  = 3'd2,
        SQ_LOW   = 3'd3,
        SQ_GUARD = 3'd4
    } sadc_state_e;

    function automatic int sadc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sadc_tmr.sv
module sadc_tmr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sadc_cap.sv
module sadc_cap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift) sh_d = {sh_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int CNT_W     = 12,
    parameter int SETUP_CYC = 4,
    parameter int GAP_CYC   = 2125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cap_shift,
    output logic             frame_done,
    output logic             cs_n,
    output logic             sclk,
    output logic             valid,
    output logic             stale
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] LAST_FALL = BIT_W'(DATA_W - 1);

    typedef struct packed {
        sadc_state_e      st;
        logic             cs_n;
        logic             sclk;
        logic [BIT_W-1:0] nfall;
        logic [DIV_W-1:0] hp;
        logic             pend;
        logic             first;
        logic             valid;
        logic             stale;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.valid  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap_shift  = 1'b0;
        frame_done = 1'b0;

        if (start && (r_q.st != SQ_IDLE)) r_d.pend = 1'b1;

        case (r_q.st)
            SQ_IDLE: begin
                if (start || r_q.pend) begin
                    r_d.st    = SQ_SETUP;
                    r_d.cs_n  = 1'b0;
                    r_d.pend  = 1'b0;
                    r_d.nfall = '0;
                    r_d.hp    = (half_div == '0) ? DIV_W'(1) : half_div;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(SETUP_CYC - 1);
                end
            end
            SQ_SETUP, SQ_LOW: begin
                if (expired) begin
                    r_d.st    = SQ_HIGH;
                    r_d.sclk  = 1'b1;
                    cap_shift = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(r_q.hp) - 1'b1;
                end
            end
            SQ_HIGH: begin
                if (expired) begin
                    r_d.sclk  = 1'b0;
                    r_d.nfall = r_q.nfall + 1'b1;
                    tmr_load  = 1'b1;
                    if (r_q.nfall == LAST_FALL) begin
                        r_d.st     = SQ_GUARD;
                        r_d.cs_n   = 1'b1;
                        r_d.valid  = 1'b1;
                        r_d.stale  = r_q.first;
                        r_d.first  = 1'b0;
                        frame_done = 1'b1;
                        tmr_val    = CNT_W'(GAP_CYC - 1);
                    end else begin
                        r_d.st  = SQ_LOW;
                        tmr_val = CNT_W'(r_q.hp) - 1'b1;
                    end
                end
            end
            SQ_GUARD: begin
                if (expired) r_d.st = SQ_IDLE;
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= SQ_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.sclk  <= 1'b0;
            r_q.nfall <= '0;
            r_q.hp    <= DIV_W'(1);
            r_q.pend  <= 1'b0;
            r_q.first <= 1'b1;
            r_q.valid <= 1'b0;
            r_q.stale <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n  = r_q.cs_n;
    assign sclk  = r_q.sclk;
    assign valid = r_q.valid;
    assign stale = r_q.stale;
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
    import sadc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int SETUP_CYC = 4,
    parameter int CONV_CYC  = 2125,
    parameter int CSH_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_div,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_sdo,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_stale
);
    localparam int GAP_CYC = sadc_max(CONV_CYC, CSH_CYC);
    localparam int MAX_CNT = sadc_max(sadc_max(GAP_CYC, 1 << DIV_W), SETUP_CYC);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              cap_shift;
    logic              frame_done;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] data_d, data_q;

    sadc_tmr #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sadc_cap #(.W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (cap_shift),
        .din   (adc_sdo),
        .q     (cap_q)
    );

    sadc_seq #(
        .DATA_W    (DATA_W),
        .DIV_W     (DIV_W),
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .half_div   (half_div),
        .expired    (tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cap_shift  (cap_shift),
        .frame_done (frame_done),
        .cs_n       (adc_cs_n),
        .sclk       (adc_sclk),
        .valid      (rd_valid),
        .stale      (rd_stale)
    );

    always_comb begin
        data_d = frame_done ? cap_q : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign rd_data = data_q;
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
    parameter int DATA_W  = 8,
    parameter int GAP_CYC = 2125
) (
    input logic clk,
    input logic rst_n,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic rd_valid,
    input logic rd_stale
);
    int   hi_cnt;
    int   rises;
    logic sclk_prev;
    logic framed;
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= 0;
            rises     <= 0;
            sclk_prev <= 1'b0;
            framed    <= 1'b0;
            seen      <= 1'b0;
        end else begin
            sclk_prev <= adc_sclk;
            if (adc_cs_n) hi_cnt <= (hi_cnt < 1000000) ? hi_cnt + 1 : hi_cnt;
            else          hi_cnt <= 0;
            if (adc_cs_n)                    rises <= 0;
            else if (adc_sclk && !sclk_prev) rises <= rises + 1;
            if (rd_valid) begin
                framed <= 1'b1;
                seen   <= 1'b1;
            end
        end
    end

    // R9
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    // R2
    setup_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> !adc_sclk);

    // R3
    eight_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (rises == DATA_W));

    // R5
    valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(adc_cs_n));

    // R5
    cs_rise_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> rd_valid);

    // R6
    guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n) && framed) |-> (hi_cnt >= GAP_CYC + 1));

    // R8
    first_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !seen) |-> rd_stale);

    // R8
    later_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && seen) |-> !rd_stale);
endmodule

bind sadc_reader sadc_reader_chk #(
    .DATA_W  (DATA_W),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk),
    .rd_valid (rd_valid),
    .rd_stale (rd_stale)
);

// File: tb/sadc_reader_test.sv
`timescale 1ns/1ps
module sadc_reader_test;
    localparam int DW    = 8;
    localparam int DIVW  = 8;
    localparam int SCYC  = 3;
    localparam int CONV  = 300;
    localparam int CSH   = 20;
    localparam int G     = (CONV > CSH) ? CONV : CSH;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [DIVW-1:0] half_div = 8'd1;
    logic            adc_cs_n, adc_sclk, rd_valid, rd_stale;
    logic            adc_sdo = 1'b0;
    logic [DW-1:0]   rd_data;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sadc_reader #(
        .DATA_W(DW), .DIV_W(DIVW), .SETUP_CYC(SCYC), .CONV_CYC(CONV), .CSH_CYC(CSH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_stale(rd_stale)
    );

    // converter model
    logic [7:0] out_word = 8'hA5;
    logic [7:0] samp = 8'h3C;
    logic [7:0] sh;
    int         nf = 0;
    logic [7:0] expq[$];

    always @(negedge adc_cs_n) begin
        sh = out_word;
        adc_sdo = sh[7];
        nf = 0;
        expq.push_back(out_word);
    end

    always @(negedge adc_sclk) begin
        if (adc_cs_n == 1'b0) begin
            nf++;
            if (nf < 8) begin
                sh = {sh[6:0], 1'b0};
                adc_sdo = sh[7];
            end else begin
                out_word = samp;
                samp = samp + 8'h4B;
            end
        end
    end

    // behavioural timeline model
    bit m_act = 0;
    bit m_pend = 0;
    int m_t = 0;
    int m_h = 1;

    function automatic int frame_end(input int h);
        return SCYC + (2 * DW - 1) * h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_pend = 0; m_t = 0;
        end else if (!m_act) begin
            if (start || m_pend) begin
                m_act = 1; m_t = 0; m_pend = 0;
                m_h = (half_div == 0) ? 1 : int'(half_div);
            end
        end else begin
            m_t++;
            if (start) m_pend = 1;
            if (m_t == frame_end(m_h) + G) m_act = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    int  frames = 0;
    bit  first_seen = 0;

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
        if (rst_n) begin
            int  fe;
            bit  e_cs, e_clk, e_val;
            fe    = frame_end(m_h);
            e_cs  = !(m_act && m_t < fe);
            e_clk = m_act && m_t >= SCYC && m_t < fe && (((m_t - SCYC) / m_h) % 2 == 0);
            e_val = m_act && m_t == fe;
            check("R2 R6 cs_n", adc_cs_n, e_cs);
            check("R3 R9 sclk", adc_sclk, e_clk);
            check("R5 rd_valid", rd_valid, e_val);
            if (rd_valid) begin
                logic [7:0] e_byte;
                frames++;
                e_byte = (expq.size() > 0) ? expq.pop_front() : 8'h00;
                check("R4 rd_data", rd_data, e_byte);
                check("R8 rd_stale", rd_stale, first_seen ? 0 : 1);
                first_seen = 1;
            end
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while ((m_act || m_pend || start) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_t(input int t);
        int guard = 0;
        while (!(m_act && m_t == t) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 cs_n reset", adc_cs_n, 1);
        check("R1 sclk reset", adc_sclk, 0);
        check("R1 valid reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs_n after", adc_cs_n, 1);
        check("R1 sclk after", adc_sclk, 0);

        // first access: stale byte, fastest clock
        half_div = 8'd1;
        pulse_start();
        wait_idle();
        check("R8 first frame count", frames, 1);

        // zero divider behaves as one
        half_div = 8'd0;
        pulse_start();
        wait_idle();

        // R3 latch and R7 coalescing inside one frame
        half_div = 8'd4;
        f0 = frames;
        pulse_start();
        wait_t(10);
        half_div = 8'd9;
        pulse_start();
        wait_t(25);
        pulse_start();
        pulse_start();
        wait_idle();
        check("R7 coalesced frames", frames - f0, 2);

        // start near the end of the guard interval
        for (int off = 1; off <= 4; off++) begin
            half_div = 8'd2;
            f0 = frames;
            pulse_start();
            wait_t(frame_end(2) + G - off);
            pulse_start();
            wait_idle();
            check("R7 R6 late start frames", frames - f0, 2);
        end

        // R9 idle line check
        check("R9 idle sclk", adc_sclk, 0);
        check("R4 queue drained", expq.size(), 0);
        finish_run();
    end
endmodule